// File: doc/BRIEF.md
# Debug Instruction Injection Engine

This engine masters a simple memory-mapped register bus that leads into the external debug register window of a processor core. The core must already be halted in debug state. For each instruction, the engine arms the core's instruction pipe by clearing the pipeline-advance flag. It then polls the debug status word until the core can accept an opcode, and writes the opcode to the instruction-transfer register. To bring a value back, it waits until the core signals that its outbound channel holds data. It then reads the two 32-bit channel halves and joins them into one 64-bit result.

A command either injects one caller-supplied opcode, or runs a full capture. A full capture first sends a no-op as a liveness probe. It then pulls out x0 through x30, followed by the program counter, the saved status word and the stack pointer. Each value appears on a result port with a register index and a one-cycle valid strobe. Every status poll is bounded by a shared, programmable cycle limit. A poll that runs past this limit aborts the command with an error.

Top module: `dii_engine`

## Requirements
- R1: After reset, cmd_ready is 1 and bus_req, res_valid, done and err are all 0. While cmd_ready is 1 the engine issues no bus request.
- R2: Each injection is three bus transfers in this order: a write of 0x8 (bit 3) to offset 0x90, one or more reads of the status word at 0x88, and a write of the opcode to 0x84. A single-instruction command (cmd_full=0) performs exactly one injection of cmd_opcode and produces no result.
- R3: The opcode write to 0x84 happens only after a status read that shows bit 25 (pipeline advance) at 0 and bit 24 (instruction empty) at 1. Status reads repeat until that holds.
- R4: A full capture (cmd_full=1) first injects the no-op 0xD503201F.
- R5: For i from 0 to 30 in ascending order, a full capture injects 0xD5130400 OR i, then performs a channel read. It outputs the value with res_idx equal to i.
- R6: After x30, a full capture injects 0xD53B4520 then 0xD5130400 and reads the program counter (res_idx 32). It then injects 0xD53B4500 then 0xD5130400 and reads the saved status (res_idx 33). Last, it injects 0x910003E0 then 0xD5130400 and reads the stack pointer (res_idx 31).
- R7: A channel read polls 0x88 until bit 29 is 1. It then reads 0x80 as bits 63:32 and 0x8C as bits 31:0 of res_data, and reads neither half before that status.
- R8: A status read that misses its condition, returning when at least tmo_limit cycles have passed since the poll's first cycle, ends the command. In that case done and err pulse together and no further bus transfer follows. A read that meets its condition always proceeds.
- R9: done pulses for one cycle at the end of a command with err at 0. After a full capture, done comes exactly one cycle after the last result strobe. A full capture yields 34 results.
- R10: While bus_req is 1 and bus_ack is 0, bus_addr, bus_we and bus_wdata stay unchanged and bus_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready is 1 |
| cmd_ready | output | 1 | Engine is idle and accepts a command |
| cmd_full | input | 1 | 1: full register capture, 0: inject cmd_opcode once |
| cmd_opcode | input | 32 | Opcode for a single-instruction command |
| tmo_limit | input | TMO_W | Cycle limit applied to every status poll |
| bus_req | output | 1 | Bus transfer request, held until acknowledged |
| bus_we | output | 1 | 1 for a write transfer |
| bus_addr | output | ADDR_W | Byte address, BASE_ADDR plus register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer complete, read data valid |
| bus_rdata | input | 32 | Read data |
| res_valid | output | 1 | One-cycle strobe for a captured value |
| res_idx | output | IDX_W | 0-30 general registers, 31 SP, 32 PC, 33 saved status |
| res_data | output | 64 | Captured value |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Set with done when a poll timed out |

## Verification
The hardest cases to reach from the ports are the timeout boundaries. There, a poll succeeds on the very read that arrives just before the limit is reached, or fails on the first unmet read at or past it. The bench's bus responder acknowledges on a fixed two-cycle rhythm and can hold back the ready or channel-full bits for a chosen number of reads. Because of that, the cycle count at each acknowledged status read is known in advance, and limit/stall pairs are picked on both sides of the boundary. A responder mode with extra wait cycles keeps requests pending long enough to show that the address and data are held. The responder also records every opcode write and flags any write that was not preceded by a run-control write and a ready status.

// File: rtl/dii_pkg.sv
package dii_pkg;
   localparam int REG_OFF_W = 12;
   localparam logic [REG_OFF_W-1:0] OFF_CHAN_HI  = 12'h080;
   localparam logic [REG_OFF_W-1:0] OFF_INSTR    = 12'h084;
   localparam logic [REG_OFF_W-1:0] OFF_STATUS   = 12'h088;
   localparam logic [REG_OFF_W-1:0] OFF_CHAN_LO  = 12'h08C;
   localparam logic [REG_OFF_W-1:0] OFF_RUNCTL   = 12'h090;

   localparam int ST_PIPE_ADV    = 25;
   localparam int ST_INSTR_EMPTY = 24;
   localparam int ST_TX_FULL     = 29;

   localparam logic [31:0] RUNCTL_CLR_PIPE = 32'h0000_0008;

   localparam logic [31:0] OPC_NOP      = 32'hD503_201F;
   localparam logic [31:0] OPC_TO_CHAN  = 32'hD513_0400;
   localparam logic [31:0] OPC_GET_PC   = 32'hD53B_4520;
   localparam logic [31:0] OPC_GET_PSR  = 32'hD53B_4500;
   localparam logic [31:0] OPC_GET_SP   = 32'h9100_03E0;

   localparam int NUM_GPR = 31;
   localparam int IDX_SP  = 31;
   localparam int IDX_PC  = 32;
   localparam int IDX_PSR = 33;

   typedef enum logic {STEP_INJECT, STEP_FETCH} step_kind_e;
endpackage

// File: rtl/dii_timer.sv
module dii_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);
   localparam logic [TMO_W-1:0] CNT_MAX = '1;

   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q >= limit);
endmodule

// File: rtl/dii_seq.sv
module dii_seq
   import dii_pkg::*;
#(
   parameter bit PROBE_FIRST = 1'b1,
   parameter int IDX_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_full,
   input  logic [31:0]      start_opcode,
   input  logic             advance,
   output step_kind_e       kind,
   output logic [31:0]      opcode,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   localparam logic [5:0] GRP_PC  = 6'(NUM_GPR);
   localparam logic [5:0] GRP_PSR = 6'(NUM_GPR + 1);
   localparam logic [5:0] GRP_SP  = 6'(NUM_GPR + 2);

   logic        full_q, probe_q, probe_init;
   logic [5:0]  grp_q;
   logic [1:0]  ph_q;
   logic [31:0] single_q;

   if (PROBE_FIRST) begin : g_probe
      assign probe_init = 1'b1;
   end else begin : g_no_probe
      assign probe_init = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         probe_q  <= 1'b0;
         grp_q    <= '0;
         ph_q     <= 2'd1;
         single_q <= '0;
      end else if (start) begin
         full_q   <= start_full;
         single_q <= start_opcode;
         probe_q  <= start_full & probe_init;
         grp_q    <= '0;
         ph_q     <= 2'd1;
      end else if (advance) begin
         if (probe_q)
            probe_q <= 1'b0;
         else if (ph_q == 2'd2) begin
            grp_q <= grp_q + 6'd1;
            ph_q  <= (grp_q >= GRP_PC - 6'd1) ? 2'd0 : 2'd1;
         end else
            ph_q <= ph_q + 2'd1;
      end
   end

   always_comb begin
      kind   = STEP_INJECT;
      opcode = single_q;
      idx    = '0;
      last   = 1'b0;
      if (!full_q)
         last = 1'b1;
      else if (probe_q)
         opcode = OPC_NOP;
      else begin
         case (ph_q)
            2'd0: opcode = (grp_q == GRP_PC)  ? OPC_GET_PC :
                           (grp_q == GRP_PSR) ? OPC_GET_PSR : OPC_GET_SP;
            2'd1: opcode = OPC_TO_CHAN | ((grp_q < GRP_PC) ? {27'd0, grp_q[4:0]} : 32'd0);
            default: begin
               kind = STEP_FETCH;
               last = (grp_q == GRP_SP);
               if (grp_q < GRP_PC)        idx = IDX_W'(grp_q);
               else if (grp_q == GRP_PC)  idx = IDX_W'(IDX_PC);
               else if (grp_q == GRP_PSR) idx = IDX_W'(IDX_PSR);
               else                       idx = IDX_W'(IDX_SP);
            end
         endcase
      end
   end
endmodule

// File: rtl/dii_port.sv
module dii_port
   import dii_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter logic [63:0] BASE_ADDR = 64'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  step_kind_e        kind,
   input  logic [31:0]       opcode,
   input  logic              tmo_expired,
   output logic              tmo_clear,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [31:0]       bus_rdata,
   output logic              step_done,
   output logic              step_err,
   output logic [63:0]       fetched,
   output logic              idle
);
   typedef enum logic [2:0] {
      P_IDLE, P_RUNCTL, P_WAIT_RDY, P_INSTR, P_WAIT_TX, P_HI, P_LO
   } port_state_e;

   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

   port_state_e st_q;
   logic [31:0] hi_q;
   logic        rdy_ok, tx_ok, polling;

   assign rdy_ok  = !bus_rdata[ST_PIPE_ADV] && bus_rdata[ST_INSTR_EMPTY];
   assign tx_ok   = bus_rdata[ST_TX_FULL];
   assign polling = (st_q == P_WAIT_RDY) || (st_q == P_WAIT_TX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= P_IDLE;
         hi_q <= '0;
      end else begin
         case (st_q)
            P_IDLE:     if (go) st_q <= (kind == STEP_INJECT) ? P_RUNCTL : P_WAIT_TX;
            P_RUNCTL:   if (bus_ack) st_q <= P_WAIT_RDY;
            P_WAIT_RDY: if (bus_ack) begin
                           if (rdy_ok)           st_q <= P_INSTR;
                           else if (tmo_expired) st_q <= P_IDLE;
                        end
            P_INSTR:    if (bus_ack) st_q <= P_IDLE;
            P_WAIT_TX:  if (bus_ack) begin
                           if (tx_ok)            st_q <= P_HI;
                           else if (tmo_expired) st_q <= P_IDLE;
                        end
            P_HI:       if (bus_ack) begin
                           hi_q <= bus_rdata;
                           st_q <= P_LO;
                        end
            P_LO:       if (bus_ack) st_q <= P_IDLE;
            default:    st_q <= P_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req   = (st_q != P_IDLE);
      bus_we    = (st_q == P_RUNCTL) || (st_q == P_INSTR);
      bus_wdata = (st_q == P_INSTR) ? opcode : RUNCTL_CLR_PIPE;
      case (st_q)
         P_RUNCTL: bus_addr = BASE + ADDR_W'(OFF_RUNCTL);
         P_INSTR:  bus_addr = BASE + ADDR_W'(OFF_INSTR);
         P_HI:     bus_addr = BASE + ADDR_W'(OFF_CHAN_HI);
         P_LO:     bus_addr = BASE + ADDR_W'(OFF_CHAN_LO);
         default:  bus_addr = BASE + ADDR_W'(OFF_STATUS);
      endcase
   end

   assign step_done = bus_ack && ((st_q == P_INSTR) || (st_q == P_LO));
   assign step_err  = bus_ack && tmo_expired &&
                      (((st_q == P_WAIT_RDY) && !rdy_ok) || ((st_q == P_WAIT_TX) && !tx_ok));
   assign fetched   = {hi_q, bus_rdata};
   assign tmo_clear = !polling;
   assign idle      = (st_q == P_IDLE);
endmodule

// File: rtl/dii_engine.sv
module dii_engine
   import dii_pkg::*;
#(
   parameter int          ADDR_W      = 32,
   parameter logic [63:0] BASE_ADDR   = 64'h0,
   parameter int          TMO_W       = 16,
   parameter int          IDX_W       = 6,
   parameter bit          PROBE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_full,
   input  logic [31:0]       cmd_opcode,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [31:0]       bus_wdata,
   input  logic              bus_ack,
   input  logic [31:0]       bus_rdata,
   output logic              res_valid,
   output logic [IDX_W-1:0]  res_idx,
   output logic [63:0]       res_data,
   output logic              done,
   output logic              err
);
   if (ADDR_W < REG_OFF_W) begin : g_bad_addr
      $error("dii_engine: ADDR_W must cover the debug register offsets");
   end
   if (IDX_W < 6) begin : g_bad_idx
      $error("dii_engine: IDX_W must hold index 33");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("dii_engine: TMO_W must be positive");
   end

   logic             running_q, fin_q, start, go;
   step_kind_e       kind;
   logic [31:0]      opcode;
   logic [IDX_W-1:0] idx;
   logic             last, step_done, step_err, port_idle, tmo_clear, tmo_expired;
   logic [63:0]      fetched;

   assign cmd_ready = !running_q;
   assign start     = cmd_valid && cmd_ready;
   assign go        = running_q && !fin_q && port_idle;

   dii_seq #(.PROBE_FIRST(PROBE_FIRST), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_full(cmd_full),
      .start_opcode(cmd_opcode), .advance(step_done), .kind(kind),
      .opcode(opcode), .idx(idx), .last(last)
   );

   dii_timer #(.TMO_W(TMO_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clear(tmo_clear), .limit(tmo_limit),
      .expired(tmo_expired)
   );

   dii_port #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_port (
      .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .opcode(opcode),
      .tmo_expired(tmo_expired), .tmo_clear(tmo_clear),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .step_done(step_done), .step_err(step_err), .fetched(fetched),
      .idle(port_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         fin_q     <= 1'b0;
         res_valid <= 1'b0;
         res_idx   <= '0;
         res_data  <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         done      <= 1'b0;
         err       <= 1'b0;
         if (start)
            running_q <= 1'b1;
         if (step_err) begin
            running_q <= 1'b0;
            done      <= 1'b1;
            err       <= 1'b1;
         end else if (step_done) begin
            if (kind == STEP_FETCH) begin
               res_valid <= 1'b1;
               res_idx   <= idx;
               res_data  <= fetched;
            end
            if (last)
               fin_q <= 1'b1;
         end
         if (fin_q) begin
            fin_q     <= 1'b0;
            running_q <= 1'b0;
            done      <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dii_engine_chk.sv
module dii_engine_chk
   import dii_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter logic [63:0] BASE_ADDR = 64'h0,
   parameter int          IDX_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_ack,
   input logic              res_valid,
   input logic [IDX_W-1:0]  res_idx,
   input logic              done,
   input logic              err
);
   localparam logic [ADDR_W-1:0] A_RUNCTL = ADDR_W'(BASE_ADDR) + ADDR_W'(OFF_RUNCTL);
   localparam logic [ADDR_W-1:0] A_INSTR  = ADDR_W'(BASE_ADDR) + ADDR_W'(OFF_INSTR);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !bus_req);

   assert_write_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> ((bus_addr == A_RUNCTL && bus_wdata == RUNCTL_CLR_PIPE) ||
                               bus_addr == A_INSTR));

   assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_idx <= IDX_W'(IDX_PSR)));

   assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_done_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !res_valid);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) &&
                                 $stable(bus_wdata)));
endmodule

bind dii_engine dii_engine_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .bus_req(bus_req), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .res_valid(res_valid),
   .res_idx(res_idx), .done(done), .err(err)
);

// File: tb/test_dii_engine.sv
`timescale 1ns/1ps
module test_dii_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_full = 1'b0;
   logic [31:0] cmd_opcode = '0;
   logic [15:0] tmo_limit = 16'd100;
   logic        bus_req, bus_we, bus_ack = 1'b0;
   logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
   logic        cmd_ready, res_valid, done, err;
   logic [5:0]  res_idx;
   logic [63:0] res_data;

   always #2.5 clk = ~clk;

   dii_engine i_dii_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_full(cmd_full), .cmd_opcode(cmd_opcode), .tmo_limit(tmo_limit),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata), .res_valid(res_valid),
      .res_idx(res_idx), .res_data(res_data), .done(done), .err(err)
   );

   localparam logic [63:0] X0_INIT = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] PC_VAL  = 64'hFFFF_0000_0008_1234;
   localparam logic [63:0] PSR_VAL = 64'h0000_0000_6000_03C5;
   localparam logic [63:0] SP_VAL  = 64'hFFFF_0000_00FE_EF00;

   // single-instruction vectors: {opcode, stall reads, stall kind (1: pipe bit shown set)}
   localparam logic [47:0] VECS [0:3] = '{
      {32'hD503201F, 8'd0, 8'd0},
      {32'h12345678, 8'd3, 8'd0},
      {32'hCAFEF00D, 8'd2, 8'd1},
      {32'h0BADBEEF, 8'd5, 8'd1}
   };

   int checks = 0, errors = 0;
   int stall_n = 0, stall_kind = 0, tx_stall_n = 0, lat = 0;
   logic [31:0] itr_log [0:63];
   logic [5:0]  ridx_log [0:63];
   logic [63:0] rdat_log [0:63];
   int itr_n = 0, res_n = 0, done_n = 0, err_n = 0, done_cyc = 0, last_res_cyc = 0;
   int viol = 0, hold_viol = 0, cyc = 0, bus_after_err = 0;
   logic pipe = 1'b0, txf = 1'b0, rdy_seen = 1'b0, rcr_seen = 1'b0, tx_seen = 1'b0;
   logic [31:0] dhi = '0, dlo = '0;
   logic [63:0] x0m = X0_INIT;

   function automatic logic [63:0] xval(input int i);
      return {32'hC0DE_0000 + 32'(i), 32'h5EED_0000 + 32'(i) * 32'h0101_0101};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic execute(input logic [31:0] op);
      if (op[31:5] == 27'(32'hD5130400 >> 5)) begin
         logic [63:0] v;
         v = (op[4:0] == 5'd0) ? x0m : xval(int'(op[4:0]));
         dhi = v[63:32];
         dlo = v[31:0];
         txf = 1'b1;
      end else if (op == 32'hD53B4520) x0m = PC_VAL;
      else if (op == 32'hD53B4500) x0m = PSR_VAL;
      else if (op == 32'h910003E0) x0m = SP_VAL;
   endtask

   task automatic serve(input logic [31:0] a, input logic w, input logic [31:0] d);
      bus_rdata = '0;
      if (w && a == 32'h90) begin
         if (d[3]) pipe = 1'b0;
         rcr_seen = 1'b1;
      end else if (w && a == 32'h84) begin
         if (!rcr_seen || !rdy_seen) viol++;
         rcr_seen = 1'b0;
         rdy_seen = 1'b0;
         itr_log[itr_n] = d;
         itr_n++;
         pipe = 1'b1;
         execute(d);
         pipe = 1'b0;
      end else if (!w && a == 32'h88) begin
         logic [31:0] s;
         s = '0;
         if (stall_n > 0) begin
            stall_n--;
            if (stall_kind != 0) begin s[25] = 1'b1; s[24] = 1'b1; end
         end else begin
            s[25] = pipe;
            s[24] = 1'b1;
         end
         if (txf) begin
            if (tx_stall_n > 0) tx_stall_n--;
            else begin s[29] = 1'b1; tx_seen = 1'b1; end
         end
         rdy_seen = !s[25] && s[24];
         bus_rdata = s;
      end else if (!w && a == 32'h80) begin
         if (!tx_seen) viol++;
         bus_rdata = dhi;
      end else if (!w && a == 32'h8C) begin
         if (!tx_seen) viol++;
         bus_rdata = dlo;
         txf = 1'b0;
         tx_seen = 1'b0;
      end else
         viol++;
   endtask

   // bus responder
   initial begin
      forever begin
         @(negedge clk);
         if (bus_ack) bus_ack = 1'b0;
         else if (bus_req) begin
            logic [31:0] a, d;
            logic w;
            a = bus_addr; w = bus_we; d = bus_wdata;
            for (int k = 0; k < lat; k++) begin
               @(negedge clk);
               if (!bus_req || bus_addr != a || bus_we != w || bus_wdata != d) hold_viol++;
            end
            serve(a, w, d);
            bus_ack = 1'b1;
         end
      end
   end

   // output monitor
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (res_valid) begin
            ridx_log[res_n] = res_idx;
            rdat_log[res_n] = res_data;
            res_n++;
            last_res_cyc = cyc;
         end
         if (done) begin
            done_n++;
            done_cyc = cyc;
            if (err) err_n++;
         end
         if (err_n > 0 && done_n > 0 && cyc > done_cyc && bus_req) bus_after_err++;
      end
   end

   task automatic run_cmd(input logic full, input logic [31:0] op, input logic [15:0] lim);
      itr_n = 0; res_n = 0; done_n = 0; err_n = 0; viol = 0; hold_viol = 0; bus_after_err = 0;
      x0m = X0_INIT; pipe = 1'b0; txf = 1'b0; tx_seen = 1'b0; rdy_seen = 1'b0; rcr_seen = 1'b0;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_full = full; cmd_opcode = op; tmo_limit = lim; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int t = 0; t < 20000 && done_n == 0; t++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cmd_ready === 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'd1);
      check(bus_req === 1'b0 && res_valid === 1'b0 && done === 1'b0 && err === 1'b0,
            "R1 outputs idle", {60'd0, bus_req, res_valid, done, err}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cmd_ready === 1'b1 && bus_req === 1'b0, "R1 after release",
            {62'd0, cmd_ready, bus_req}, 64'd2);

      // R2, R3: single-instruction vectors
      for (int v = 0; v < 4; v++) begin
         stall_n = int'(VECS[v][15:8]);
         stall_kind = int'(VECS[v][7:0]);
         run_cmd(1'b0, VECS[v][47:16], 16'd100);
         check(itr_n == 1 && itr_log[0] == VECS[v][47:16], "R2 single opcode",
               64'(itr_log[0]), 64'(VECS[v][47:16]));
         check(res_n == 0 && done_n == 1 && err_n == 0, "R2 single done no result",
               64'(res_n), 64'd0);
         check(viol == 0, "R3 handshake order", 64'(viol), 64'd0);
      end

      // R4..R7, R9: full capture
      tx_stall_n = 3;
      run_cmd(1'b1, 32'h0, 16'd100);
      check(itr_n == 38, "R4 injection count", 64'(itr_n), 64'd38);
      check(itr_log[0] == 32'hD503201F, "R4 probe first", 64'(itr_log[0]), 64'hD503201F);
      for (int i = 0; i < 31; i++)
         check(itr_log[1 + i] == (32'hD5130400 | 32'(i)), "R5 gpr opcode",
               64'(itr_log[1 + i]), 64'(32'hD5130400 | 32'(i)));
      check(itr_log[32] == 32'hD53B4520 && itr_log[33] == 32'hD5130400, "R6 pc opcodes",
            {itr_log[32], itr_log[33]}, {32'hD53B4520, 32'hD5130400});
      check(itr_log[34] == 32'hD53B4500 && itr_log[35] == 32'hD5130400, "R6 psr opcodes",
            {itr_log[34], itr_log[35]}, {32'hD53B4500, 32'hD5130400});
      check(itr_log[36] == 32'h910003E0 && itr_log[37] == 32'hD5130400, "R6 sp opcodes",
            {itr_log[36], itr_log[37]}, {32'h910003E0, 32'hD5130400});
      check(res_n == 34, "R9 result count", 64'(res_n), 64'd34);
      for (int i = 0; i < 31; i++) begin
         logic [63:0] e;
         e = (i == 0) ? X0_INIT : xval(i);
         check(ridx_log[i] == 6'(i) && rdat_log[i] == e, "R5 gpr value", rdat_log[i], e);
      end
      check(ridx_log[31] == 6'd32 && rdat_log[31] == PC_VAL, "R6 pc value", rdat_log[31], PC_VAL);
      check(ridx_log[32] == 6'd33 && rdat_log[32] == PSR_VAL, "R6 psr value", rdat_log[32], PSR_VAL);
      check(ridx_log[33] == 6'd31 && rdat_log[33] == SP_VAL, "R6 sp value", rdat_log[33], SP_VAL);
      check(viol == 0, "R7 channel read after tx full", 64'(viol), 64'd0);
      check(done_n == 1 && err_n == 0 && done_cyc == last_res_cyc + 1, "R9 done timing",
            64'(done_cyc), 64'(last_res_cyc + 1));

      // R10: slow bus keeps requests pending
      lat = 2;
      run_cmd(1'b1, 32'h0, 16'd200);
      check(hold_viol == 0, "R10 request held", 64'(hold_viol), 64'd0);
      check(res_n == 34 && err_n == 0, "R10 capture under wait states", 64'(res_n), 64'd34);
      lat = 0;

      // R8: timeout boundary (status reads acknowledged at 1, 3, 5 cycles into the poll)
      stall_n = 1; stall_kind = 0;
      run_cmd(1'b0, 32'hA5A5A5A5, 16'd3);
      check(err_n == 0 && itr_n == 1, "R8 ready just inside limit", 64'(err_n), 64'd0);
      stall_n = 2; stall_kind = 1;
      run_cmd(1'b0, 32'hA5A5A5A5, 16'd3);
      check(err_n == 1 && done_n == 1 && itr_n == 0, "R8 unmet at limit aborts",
            {32'(err_n), 32'(itr_n)}, {32'd1, 32'd0});
      check(bus_after_err == 0 && cmd_ready === 1'b1, "R8 bus quiet after abort",
            64'(bus_after_err), 64'd0);
      stall_n = 0;

      // R7, R8: channel never fills
      tx_stall_n = 1000;
      run_cmd(1'b1, 32'h0, 16'd6);
      check(err_n == 1 && res_n == 0 && itr_n == 2, "R7 tx wait times out",
            {32'(err_n), 32'(itr_n)}, {32'd1, 32'd2});
      tx_stall_n = 0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule